// File: doc/BRIEF.md
# Snooping Data-Cache Tag Unit

This unit holds the tag and valid state of a small direct-mapped data cache. It keeps that state coherent with external memory while another master holds the system bus. The processor side looks up an address and gets a hit flag. The refill side installs a tag into a line once the bus belongs to the processor again. While another master owns the bus, the unit watches that master's bus cycles. If the ownership was granted as snoop-class, each write is compared against the tag of the line it selects, and a matching line is invalidated in the same clock. Writes made under general-class ownership leave the cache untouched, so coherence for those writes rests with software.

The unit also decides when the processor pipeline must wait. Under snoop-class ownership, every data-cache access waits, because the tag array is busy watching the bus. Under either class of ownership, an instruction-cache miss waits. Under general-class ownership, a data-cache hit may proceed. A data-cache miss or an instruction-cache miss, however, raises a request that the foreign master release the bus, and the pipeline keeps waiting until the bus comes back. A flush input clears every line in one cycle.

Top module: `snoop_dcache_tags`

## Requirements
- R1: After synchronous reset, every line is invalid: no lookup hits, and `stall`, `bus_rel_req` and `snoop_inv` are low while the bus is not foreign-owned.
- R2: With `fill_en` high while `ext_own` is low, the tag field `addr[31:10]` of `fill_addr` is written into line `addr[9:4]`, and that line is set valid. From the next cycle, `cpu_hit` is high for any `cpu_addr` with the same index and tag, whatever its bits `[3:0]`.
- R3: A bus write (`bus_valid` and `bus_write` high) under snoop-class ownership (`ext_own` and `own_snoop` high) that hits a valid line with the same tag raises `snoop_inv` in that cycle and clears the line from the next cycle. Writes on consecutive cycles are each handled.
- R4: A snoop-class bus write whose line is invalid, or whose tag differs, changes no line and leaves `snoop_inv` low.
- R5: Bus writes under general-class ownership (`ext_own` high, `own_snoop` low) never invalidate a line.
- R6: Bus read cycles (`bus_write` low) never change any line.
- R7: `flush` clears every line in one cycle and overrides a fill in the same cycle.
- R8: Under snoop-class ownership, `cpu_dc_req` raises `stall`, whether the lookup hits or misses, and never raises `bus_rel_req`.
- R9: While `ext_own` is high, `ic_miss` raises `stall` for either ownership class.
- R10: Under general-class ownership, a data-cache miss (`cpu_dc_req` with no hit) or `ic_miss` raises both `stall` and `bus_rel_req`. A data-cache hit raises neither.
- R11: While `ext_own` is low, `stall` and `bus_rel_req` are low.
- R12: `fill_en` is ignored while `ext_own` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| ext_own | input | 1 | Another master owns the bus |
| own_snoop | input | 1 | Current foreign ownership is snoop-class |
| bus_valid | input | 1 | Foreign master bus cycle present |
| bus_write | input | 1 | The bus cycle is a write |
| bus_addr | input | 32 | Bus cycle byte address |
| fill_en | input | 1 | Install a tag from the refill side |
| fill_addr | input | 32 | Address of the line being installed |
| cpu_dc_req | input | 1 | Processor data-cache access |
| cpu_addr | input | 32 | Processor data-cache address |
| ic_miss | input | 1 | Processor instruction-cache miss |
| cpu_hit | output | 1 | Lookup of `cpu_addr` hits a valid line |
| snoop_inv | output | 1 | A line is being invalidated this cycle |
| stall | output | 1 | Hold the processor pipeline |
| bus_rel_req | output | 1 | Ask the foreign master to release the bus |

## Verification
The bench builds the unit with its default geometry: 32-bit addresses and 64 lines of 16 bytes. This gives a 22-bit tag, a 6-bit index and a 4-bit offset. Addresses are drawn from four tags over all 64 indices. Aliasing lines, tag mismatches on valid lines, and back-to-back snoop hits on the same line therefore occur often. The bench's own model predicts every output on every clock through mixed ownership, fill, flush and read traffic.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_BYTES = 16;
    localparam int DEF_LINES      = 64;

    // Who currently holds the bus, as seen from the cache.
    typedef enum logic [1:0] {
        OWN_LOCAL   = 2'd0,
        OWN_GENERAL = 2'd1,
        OWN_SNOOP   = 2'd2
    } own_mode_e;

    typedef struct packed {
        logic valid;
        logic write;
    } bus_kind_t;

    function automatic own_mode_e decode_own(input logic ext, input logic snp);
        if (!ext)
            return OWN_LOCAL;
        else if (snp)
            return OWN_SNOOP;
        else
            return OWN_GENERAL;
    endfunction

endpackage

// File: rtl/sdc_tag_array.sv
module sdc_tag_array #(
    parameter int LINES = 64,
    parameter int TAG_W = 22,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_valid,
    output logic [TAG_W-1:0] cpu_tag,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_valid,
    output logic [TAG_W-1:0] snp_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (flush) begin
                valid_q[g] <= 1'b0;
            end else if (inv_en && inv_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= fill_tag;
            end
        end
    end

    assign cpu_valid = valid_q[cpu_idx];
    assign cpu_tag   = tag_q[cpu_idx];
    assign snp_valid = valid_q[snp_idx];
    assign snp_tag   = tag_q[snp_idx];

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> valid_q == '0);

    // R3
    inv_clears_line_chk: assert property (@(posedge clk) disable iff (rst)
        inv_en && !(fill_en && fill_idx == inv_idx) |=> !valid_q[$past(inv_idx)]);

    // R2
    fill_sets_line_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en && !flush && !(inv_en && inv_idx == fill_idx) |=> valid_q[$past(fill_idx)]);

    // R4 R5 R6
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        !inv_en && !fill_en && !flush |=> valid_q == $past(valid_q));

endmodule

// File: rtl/sdc_snoop_ctl.sv
module sdc_snoop_ctl
    import sdc_pkg::*;
#(
    parameter int TAG_W = 22
) (
    input  own_mode_e        mode,
    input  bus_kind_t        kind,
    input  logic [TAG_W-1:0] bus_tag,
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    output logic             inv_en
);

    logic snoop_write;

    always_comb begin
        snoop_write = (mode == OWN_SNOOP) && kind.valid && kind.write;
        inv_en      = snoop_write && line_valid && (line_tag == bus_tag);
    end

endmodule

// File: rtl/sdc_stall_gen.sv
module sdc_stall_gen
    import sdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  own_mode_e mode,
    input  logic      cpu_dc_req,
    input  logic      cpu_hit,
    input  logic      ic_miss,
    output logic      stall,
    output logic      rel_req
);

    logic dc_miss;

    always_comb begin
        dc_miss = cpu_dc_req && !cpu_hit;
        stall   = 1'b0;
        rel_req = 1'b0;
        unique case (mode)
            OWN_SNOOP: begin
                stall = cpu_dc_req || ic_miss;
            end
            OWN_GENERAL: begin
                rel_req = dc_miss || ic_miss;
                stall   = dc_miss || ic_miss;
            end
            default: begin
                stall   = 1'b0;
                rel_req = 1'b0;
            end
        endcase
    end

    // R10
    rel_implies_stall_chk: assert property (@(posedge clk) disable iff (rst)
        rel_req |-> stall);

    // R8
    snoop_no_release_chk: assert property (@(posedge clk) disable iff (rst)
        mode == OWN_SNOOP |-> !rel_req);

    // R11
    local_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        mode == OWN_LOCAL |-> !stall && !rel_req);

endmodule

// File: rtl/snoop_dcache_tags.sv
module snoop_dcache_tags
    import sdc_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int LINES      = DEF_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ext_own,
    input  logic              own_snoop,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              cpu_dc_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              ic_miss,
    output logic              cpu_hit,
    output logic              snoop_inv,
    output logic              stall,
    output logic              bus_rel_req
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    own_mode_e        mode;
    bus_kind_t        kind;
    logic [IDX_W-1:0] cpu_idx, bus_idx, fill_idx;
    logic [TAG_W-1:0] cpu_tag, bus_tag, fill_tag;
    logic             cpu_line_valid, snp_line_valid;
    logic [TAG_W-1:0] cpu_line_tag, snp_line_tag;
    logic             inv_en, fill_go;
    logic             unused_offsets;

    assign mode     = decode_own(ext_own, own_snoop);
    assign kind     = '{valid: bus_valid, write: bus_write};
    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign bus_idx  = bus_addr[OFF_W +: IDX_W];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign bus_tag  = bus_addr[ADDR_W-1 -: TAG_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{cpu_addr[OFF_W-1:0], bus_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    // The refill engine may only install lines once the bus is back home.
    assign fill_go = fill_en && (mode == OWN_LOCAL);

    sdc_tag_array #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .cpu_idx  (cpu_idx),
        .cpu_valid(cpu_line_valid),
        .cpu_tag  (cpu_line_tag),
        .snp_idx  (bus_idx),
        .snp_valid(snp_line_valid),
        .snp_tag  (snp_line_tag),
        .fill_en  (fill_go),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .inv_en   (inv_en),
        .inv_idx  (bus_idx)
    );

    sdc_snoop_ctl #(.TAG_W(TAG_W)) u_snoop (
        .mode      (mode),
        .kind      (kind),
        .bus_tag   (bus_tag),
        .line_valid(snp_line_valid),
        .line_tag  (snp_line_tag),
        .inv_en    (inv_en)
    );

    assign cpu_hit   = cpu_line_valid && (cpu_line_tag == cpu_tag);
    assign snoop_inv = inv_en;

    sdc_stall_gen u_stall (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cpu_dc_req(cpu_dc_req),
        .cpu_hit   (cpu_hit),
        .ic_miss   (ic_miss),
        .stall     (stall),
        .rel_req   (bus_rel_req)
    );

    // R12
    fill_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ext_own && fill_en && !flush && !inv_en && cpu_addr == fill_addr && !cpu_hit
        |=> !cpu_hit || !$stable(cpu_addr));

endmodule

// File: tb/test_snoop_dcache_tags.sv
module test_snoop_dcache_tags;

    logic        clk = 1'b0;
    logic        rst, flush, ext_own, own_snoop, bus_valid, bus_write;
    logic [31:0] bus_addr, fill_addr, cpu_addr;
    logic        fill_en, cpu_dc_req, ic_miss;
    logic        cpu_hit, snoop_inv, stall, bus_rel_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural reference state
    bit      m_valid [64];
    int      m_tag   [64];

    always #2 clk = ~clk;

    snoop_dcache_tags i_snoop_dcache_tags (
        .clk(clk), .rst(rst), .flush(flush), .ext_own(ext_own), .own_snoop(own_snoop),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .fill_en(fill_en), .fill_addr(fill_addr), .cpu_dc_req(cpu_dc_req),
        .cpu_addr(cpu_addr), .ic_miss(ic_miss), .cpu_hit(cpu_hit),
        .snoop_inv(snoop_inv), .stall(stall), .bus_rel_req(bus_rel_req)
    );

    function automatic int idx_of(input logic [31:0] a); return int'(a[9:4]); endfunction
    function automatic int tag_of(input logic [31:0] a); return int'(a[31:10]); endfunction

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs mid-cycle, then advance one clock and update the model.
    task automatic step(input string req);
        bit e_hit, e_inv, e_stall, e_rel, dmiss;
        int ci, bi;
        #1;
        ci = idx_of(cpu_addr);
        bi = idx_of(bus_addr);
        e_hit = m_valid[ci] && m_tag[ci] == tag_of(cpu_addr);
        e_inv = ext_own && own_snoop && bus_valid && bus_write &&
                m_valid[bi] && m_tag[bi] == tag_of(bus_addr);
        dmiss = cpu_dc_req && !e_hit;
        e_stall = ext_own && ((own_snoop && cpu_dc_req) || ic_miss || (!own_snoop && dmiss));
        e_rel = ext_own && !own_snoop && (ic_miss || dmiss);
        if (!rst) begin
            check1(req, "cpu_hit", cpu_hit, e_hit);
            check1(req, "snoop_inv", snoop_inv, e_inv);
            check1(req, "stall", stall, e_stall);
            check1(req, "bus_rel_req", bus_rel_req, e_rel);
        end
        @(posedge clk);
        if (rst || flush) begin
            for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
        end else begin
            if (e_inv) m_valid[bi] = 1'b0;
            if (fill_en && !ext_own) begin
                m_valid[idx_of(fill_addr)] = 1'b1;
                m_tag[idx_of(fill_addr)] = tag_of(fill_addr);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        flush = 0; ext_own = 0; own_snoop = 0; bus_valid = 0; bus_write = 0;
        fill_en = 0; cpu_dc_req = 0; ic_miss = 0;
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return {tag[21:0], idx[5:0], off[3:0]};
    endfunction

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) begin m_valid[i] = 0; m_tag[i] = 0; end
        idle();
        rst = 1; bus_addr = 0; fill_addr = 0; cpu_addr = 0;
        @(negedge clk);
        repeat (3) step("R1");
        rst = 0;
        // R1: nothing hits after reset
        for (int i = 0; i < 8; i++) begin
            cpu_addr = mk(i, i * 7, i); cpu_dc_req = 1; step("R1");
        end
        // R2: fill then lookup, offsets ignored
        fill_en = 1; fill_addr = mk(3, 5, 0); step("R2");
        fill_addr = mk(1, 6, 9); step("R2");
        fill_en = 0; cpu_addr = mk(3, 5, 15); step("R2");
        cpu_addr = mk(2, 5, 0); step("R2");
        cpu_addr = mk(1, 6, 3); step("R11");
        // R12: fill ignored during foreign ownership
        ext_own = 1; own_snoop = 1; cpu_dc_req = 0;
        fill_en = 1; fill_addr = mk(7, 9, 0); step("R12");
        fill_en = 0; ext_own = 0; cpu_addr = mk(7, 9, 0); cpu_dc_req = 1; step("R12");
        // R6: read does not invalidate
        ext_own = 1; own_snoop = 1; cpu_dc_req = 0;
        bus_valid = 1; bus_write = 0; bus_addr = mk(3, 5, 4); step("R6");
        // R4: tag mismatch write
        bus_write = 1; bus_addr = mk(0, 5, 0); step("R4");
        // R5: general-class write matching
        own_snoop = 0; bus_addr = mk(3, 5, 0); step("R5");
        // R3: back-to-back snoop hits on two lines, then repeated on same line
        own_snoop = 1; bus_addr = mk(3, 5, 8); step("R3");
        bus_addr = mk(1, 6, 0); step("R3");
        bus_addr = mk(1, 6, 0); step("R4");
        bus_valid = 0; ext_own = 0; cpu_dc_req = 1; cpu_addr = mk(3, 5, 0); step("R3");
        // R8/R9/R10 on a hit and a miss
        fill_en = 1; fill_addr = mk(2, 2, 0); cpu_dc_req = 0; step("R2");
        fill_en = 0; ext_own = 1; own_snoop = 1; cpu_dc_req = 1; cpu_addr = mk(2, 2, 0); step("R8");
        cpu_addr = mk(3, 2, 0); step("R8");
        cpu_dc_req = 0; ic_miss = 1; step("R9");
        own_snoop = 0; step("R9");
        ic_miss = 0; cpu_dc_req = 1; step("R10");
        cpu_addr = mk(2, 2, 0); step("R10");
        // R7: flush overrides fill
        ext_own = 0; flush = 1; fill_en = 1; fill_addr = mk(0, 0, 0); step("R7");
        flush = 0; fill_en = 0; cpu_addr = mk(0, 0, 0); step("R7");
        cpu_addr = mk(2, 2, 0); step("R7");
        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            flush      = ($urandom_range(0, 199) == 0);
            ext_own    = ($urandom_range(0, 2) != 0);
            own_snoop  = $urandom_range(0, 1);
            bus_valid  = $urandom_range(0, 1);
            bus_write  = ($urandom_range(0, 3) != 0);
            bus_addr   = mk($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 15));
            fill_en    = $urandom_range(0, 1);
            fill_addr  = mk($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 15));
            cpu_dc_req = $urandom_range(0, 1);
            cpu_addr   = mk($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 15));
            ic_miss    = ($urandom_range(0, 3) == 0);
            step("R3R5R10");
        end
        idle();
        step("R11");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule